// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block sits between a CPU bus and a cartridge ROM. CPU writes that land in the lower 16 KiB of the address space do not reach the ROM. They load one of two 4-bit control registers instead. CPU address bit 8 chooses which register is loaded. One register holds the number of the ROM bank that appears in the upper 16 KiB window. The other register gates access to a small built-in memory.

For every CPU address, the block computes an 18-bit physical ROM address. The lower window always maps to bank 0. The upper window maps to the selected bank.

The built-in memory has 512 cells of 4 bits each. It appears throughout the 8 KiB external-RAM window at 0xA000-0xBFFF, repeated every 512 bytes. Toward the CPU its data port is 8 bits wide. The missing upper nibble reads back as ones. The memory only responds once the gate register holds the unlock value.

Top module: `nibble_cart_ctrl`

## Requirements
- R1: After reset the bank register holds 1 and the gate register holds 0. A read of 0x4000 therefore yields ROM address 0x04000, and a read of 0xA000 yields data 0xFF.
- R2: For CPU addresses 0x0000-0x3FFF, ROM address bits [17:14] are 0 and bits [13:0] equal CPU address bits [13:0].
- R3: For CPU addresses 0x4000-0x7FFF, ROM address bits [17:14] equal the bank register and bits [13:0] equal CPU address bits [13:0].
- R4: A write to 0x0000-0x3FFF loads data bits [3:0]. It loads the gate register when CPU address bit 8 is 0, and the bank register when bit 8 is 1. The other register is left unchanged.
- R5: Writing bank value 0 stores 1, so the bank register is never 0.
- R6: The memory is open only while the gate register equals 0xA. Any read outside 0xA000-0xBFFF, or any read while the memory is closed, yields 0xFF.
- R7: A write to 0xA000-0xBFFF while the memory is closed changes no cell.
- R8: An open memory read returns the stored nibble in data bits [3:0] and ones in bits [7:4]. Written data bits [7:4] are dropped.
- R9: Only CPU address bits [8:0] select a cell. Any two addresses in 0xA000-0xBFFF that share those bits reach the same cell.
- R10: A memory write takes effect at the clock edge. During the write cycle, a read of the same cell still returns the old contents. The new contents appear from the next cycle on.
- R11: Writes to 0x4000-0x9FFF and to 0xC000-0xFFFF change neither register nor any cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one write per cycle |
| rom_addr | output | 18 | Physical ROM address for the current CPU address |
| ram_rdata | output | 8 | Read data from the built-in memory, 0xFF when not driven |

## Verification
The read path and the write path of the nibble memory can act in the same cycle on the same cell. This happens when the CPU holds a memory address with the strobe high: the combinational read is presented while the write is pending. The bench provokes it by setting a new value on a cell whose old value it knows. It samples one time unit after the falling edge and expects the old value. It then samples again just after the next rising edge and expects the new value. A second case overlaps a control-register write with the ROM address output. The bank value is checked only from the cycle after its write edge.

// File: rtl/nibble_cart_pkg.sv
package nibble_cart_pkg;

    localparam int CPU_AW = 16;
    localparam int CPU_DW = 8;

    typedef enum logic [1:0] {
        WIN_ROM_LO = 2'd0,
        WIN_ROM_HI = 2'd1,
        WIN_RAM    = 2'd2,
        WIN_OTHER  = 2'd3
    } win_e;

    // Coarse window decode of a CPU address.
    function automatic win_e decode_window(input logic [CPU_AW-1:0] a);
        win_e w;
        if (a[15:14] == 2'b00)
            w = WIN_ROM_LO;
        else if (a[15:14] == 2'b01)
            w = WIN_ROM_HI;
        else if (a[15:13] == 3'b101)
            w = WIN_RAM;
        else
            w = WIN_OTHER;
        return w;
    endfunction

endpackage

// File: rtl/nc_ctrl_regs.sv
module nc_ctrl_regs #(
    parameter int BANK_W = 4,
    parameter int NIB_W  = 4,
    parameter logic [NIB_W-1:0] GATE_KEY = 4'hA,
    localparam int FIELD_W = (BANK_W > NIB_W) ? BANK_W : NIB_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic               ctl_sel_bank,
    input  logic [FIELD_W-1:0] ctl_val,
    output logic [NIB_W-1:0]   gate_q,
    output logic [BANK_W-1:0]  bank_q,
    output logic               ram_open
);

    typedef struct packed {
        logic [NIB_W-1:0]  gate;
        logic [BANK_W-1:0] bank;
    } ctl_regs_t;

    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (ctl_wr) begin
            if (ctl_sel_bank) begin
                if (ctl_val[BANK_W-1:0] == '0)
                    regs_d.bank = BANK_ONE;
                else
                    regs_d.bank = ctl_val[BANK_W-1:0];
            end else begin
                regs_d.gate = ctl_val[NIB_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.gate <= '0;
            regs_q.bank <= BANK_ONE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign gate_q   = regs_q.gate;
    assign bank_q   = regs_q.bank;
    assign ram_open = (regs_q.gate == GATE_KEY);

    assert_bank_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != '0);

    assert_gate_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_sel_bank) |=> (gate_q == $past(ctl_val[NIB_W-1:0])) && $stable(bank_q));

endmodule

// File: rtl/nc_rom_map.sv
module nc_rom_map #(
    parameter int BANK_W = 4,
    parameter int OFS_W  = 14,
    localparam int ROM_AW = BANK_W + OFS_W
) (
    input  logic [OFS_W:0]    win_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [ROM_AW-1:0] rom_addr
);

    logic [BANK_W-1:0] eff_bank;

    always_comb begin
        // Bit OFS_W separates the fixed lower window from the switched one.
        eff_bank = win_addr[OFS_W] ? bank : '0;
        rom_addr = {eff_bank, win_addr[OFS_W-1:0]};
    end

endmodule

// File: rtl/nc_nibble_ram.sv
module nc_nibble_ram #(
    parameter int AW    = 9,
    parameter int NIB_W = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [NIB_W-1:0] wnib,
    output logic [NIB_W-1:0] rnib
);

    logic [NIB_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[addr] <= wnib;
    end

    assign rnib = cells[addr];

    assert_write_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (addr != $past(addr)) || (rnib == $past(wnib)));

endmodule

// File: rtl/nibble_cart_ctrl.sv
module nibble_cart_ctrl
    import nibble_cart_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int NIB_W   = 4,
    parameter int RAM_AW  = 9,
    parameter int OFS_W   = 14,
    parameter int SEL_BIT = 8,
    parameter logic [NIB_W-1:0] GATE_KEY = 4'hA,
    localparam int ROM_AW  = BANK_W + OFS_W,
    localparam int FIELD_W = (BANK_W > NIB_W) ? BANK_W : NIB_W,
    localparam int PAD_W   = CPU_DW - NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_wdata,
    input  logic              cpu_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [CPU_DW-1:0] ram_rdata
);

    win_e              win;
    logic              ctl_wr;
    logic              ram_we;
    logic              ram_open;
    logic [NIB_W-1:0]  gate_q;
    logic [BANK_W-1:0] bank_q;
    logic [NIB_W-1:0]  rnib;
    logic              unused_hi_data;

    assign win    = decode_window(cpu_addr);
    assign ctl_wr = cpu_wr && (win == WIN_ROM_LO);
    assign ram_we = cpu_wr && (win == WIN_RAM) && ram_open;
    assign unused_hi_data = ^cpu_wdata[CPU_DW-1:FIELD_W];

    nc_ctrl_regs #(
        .BANK_W   (BANK_W),
        .NIB_W    (NIB_W),
        .GATE_KEY (GATE_KEY)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_sel_bank (cpu_addr[SEL_BIT]),
        .ctl_val      (cpu_wdata[FIELD_W-1:0]),
        .gate_q       (gate_q),
        .bank_q       (bank_q),
        .ram_open     (ram_open)
    );

    nc_rom_map #(
        .BANK_W (BANK_W),
        .OFS_W  (OFS_W)
    ) u_map (
        .win_addr (cpu_addr[OFS_W:0]),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    nc_nibble_ram #(
        .AW    (RAM_AW),
        .NIB_W (NIB_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .addr  (cpu_addr[RAM_AW-1:0]),
        .wnib  (cpu_wdata[NIB_W-1:0]),
        .rnib  (rnib)
    );

    always_comb begin
        if (win == WIN_RAM && ram_open)
            ram_rdata = {{PAD_W{1'b1}}, rnib};
        else
            ram_rdata = '1;
    end

    assert_low_bank_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:OFS_W] == '0));

    assert_closed_reads_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q != GATE_KEY) |-> (ram_rdata == '1));

    assert_far_write_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:14] != 2'b00) |=> $stable(gate_q) && $stable(bank_q));

endmodule

// File: tb/sim_nibble_cart_ctrl.sv
module sim_nibble_cart_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic [17:0] rom_addr;
    logic [7:0]  ram_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] shadow [512];

    always #5 clk = ~clk;

    nibble_cart_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .rom_addr  (rom_addr),
        .ram_rdata (ram_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        look(16'h4000);
        check("R1 bank", 32'(rom_addr), 32'h04000);
        look(16'hA000);
        check("R1 ram closed", 32'(ram_rdata), 32'hFF);

        // R2 lower window sweep
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            a = 16'((i * 16'h0107) & 16'h3FFF);
            look(a);
            check("R2 low window", 32'(rom_addr), 32'(a[13:0]));
        end

        // R3 R4 R5 bank register sweep
        for (int v = 0; v < 16; v++) begin
            logic [15:0] wa;
            logic [13:0] ofs;
            logic [3:0]  eb;
            wa  = (v[0]) ? 16'h3F00 : 16'h2100;
            bus_write(wa, 8'(8'hA0 | v));
            ofs = 14'((v * 14'h0333) & 14'h3FFF);
            eb  = (v == 0) ? 4'd1 : 4'(v);
            look(16'h4000 | 16'(ofs));
            check((v == 0) ? "R5 bank zero" : "R3 bank map", 32'(rom_addr), {14'd0, eb, ofs});
        end
        bus_write(16'h2100, 8'h07);

        // open memory, seed cell 0
        bus_write(16'h1000, 8'h0A);
        bus_write(16'hA000, 8'h03);
        shadow[0] = 4'h3;

        // R4 R6 R7 gate sweep
        for (int g = 0; g < 16; g++) begin
            bus_write(16'h10F0 | 16'(g), 8'(g));
            look(16'hA000);
            check("R6 gate", 32'(ram_rdata), (g == 10) ? 32'hF3 : 32'hFF);
            look(16'h5000);
            check("R4 gate write keeps bank", 32'(rom_addr), {14'd0, 4'd7, 14'h1000});
            if (g != 10) begin
                bus_write(16'hA000, 8'h09);
                bus_write(16'h0000, 8'h0A);
                look(16'hA000);
                check("R7 closed write", 32'(ram_rdata), 32'hF3);
            end
        end

        // R6 open but outside window
        bus_write(16'h0000, 8'h0A);
        look(16'hC000);
        check("R6 outside window", 32'(ram_rdata), 32'hFF);

        // R8 R9 fill through varied aliases, read through other aliases
        for (int i = 0; i < 512; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + 8'h5B) & 8'hFF);
            bus_write(16'hA000 + 16'((i % 16) * 16'h200) + 16'(i), d);
            shadow[i] = d[3:0];
        end
        for (int i = 0; i < 512; i++) begin
            look(16'hA000 + 16'(((i + 5) % 16) * 16'h200) + 16'(i));
            check("R9 R8 alias read", 32'(ram_rdata), {24'd0, 4'hF, shadow[i]});
        end

        // R10 same-cycle read and write of one cell
        @(negedge clk);
        cpu_addr  = 16'hA005;
        cpu_wdata = 8'(~shadow[5]);
        cpu_wr    = 1'b1;
        #1;
        check("R10 old during write", 32'(ram_rdata), {24'd0, 4'hF, shadow[5]});
        @(posedge clk);
        #1;
        check("R10 new after edge", 32'(ram_rdata), {24'd0, 4'hF, ~shadow[5]});
        @(negedge clk);
        cpu_wr = 1'b0;
        shadow[5] = ~shadow[5];

        // R11 writes elsewhere change nothing
        bus_write(16'h4100, 8'h0C);
        bus_write(16'h6000, 8'h00);
        bus_write(16'h8000, 8'h05);
        bus_write(16'hC000, 8'h0E);
        bus_write(16'hE105, 8'h01);
        look(16'h7FFF);
        check("R11 bank kept", 32'(rom_addr), {14'd0, 4'd7, 14'h3FFF});
        look(16'hA000);
        check("R11 cell 0 kept", 32'(ram_rdata), {24'd0, 4'hF, shadow[0]});
        look(16'hA105);
        check("R11 cell 105 kept", 32'(ram_rdata), {24'd0, 4'hF, shadow[9'h105]});

        // R1 reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(16'h4000);
        check("R1 bank after reset", 32'(rom_addr), 32'h04000);
        look(16'hA000);
        check("R1 gate after reset", 32'(ram_rdata), 32'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule